// File: doc/BRIEF.md
# Subtractive Memory-Read Target for PCI

This block sits on a PCI bus as the agent of last resort for memory reads. It watches every address phase. When the command is a memory read and no other agent has answered with DEVSEL by the end of a fixed window, it claims the cycle itself. It then either asks the initiator to retry or passes the read to a slower downstream bus through a request/acknowledge port.

The retry decision is made at the clock on which the cycle is claimed. A cycle is retried when the bridge is locked, when buffer management work is pending, or when another master or DMA owns the downstream bus. If the cause is a busy downstream bus, a downstream bus request is raised so that a later attempt can succeed.

An accepted read holds the initiator in wait states until the downstream read returns. The returned word is then driven with TRDY for exactly one data transfer. If the initiator wanted a burst, the block ends the burst after the first word with a disconnect. A downstream side that never answers still ends the cycle after a standard-length window. In that case the value present on the downstream data bus is returned.

Top module: `pci_subtr_rd_tgt`

## Requirements
- R1: A memory read (command code 0110, 1100 or 1110 on cbe_i[3:0] in the address phase) is claimed on the fourth clock edge after the address edge, so devsel_o rises after that edge and is low after edges one to three.
- R2: If other_devsel_i is sampled high on any of the four edges after the address edge, that transaction asserts none of devsel_o, trdy_o, stop_o or ds_req_o.
- R3: Any other command code is ignored: devsel_o, trdy_o, stop_o and ds_req_o stay low for the whole transaction.
- R4: If lock_i, buf_busy_i or ds_busy_i is high at the claim edge, the cycle is retried: devsel_o and stop_o high, trdy_o low, and no downstream request.
- R5: A retry in which ds_busy_i is high sets ds_bus_req_o, which stays high while ds_busy_i stays high and clears one edge after ds_busy_i is sampled low. A retry without that cause, or no retry at all, leaves it low.
- R6: An accepted cycle raises ds_req_o from the claim edge until the completion edge. During that time ds_addr_o holds the address-phase address and ds_be_o holds the byte enables sampled at the claim edge, and trdy_o stays low.
- R7: After the edge on which ds_ack_i is sampled high, trdy_o is high with ad_o equal to ds_data_i from that edge and ad_oe_o high. trdy_o falls after the first edge with irdy_i high.
- R8: If ds_ack_i stays low, the read completes on the DS_STD_LEN-th edge after the request edge and returns the ds_data_i value sampled on that edge.
- R9: If frame_i is still high at the completion edge (a burst), stop_o is raised together with trdy_o. After the transfer, stop_o and devsel_o stay high until frame_i and irdy_i are both low.
- R10: After any transaction, the block returns to idle with devsel_o, trdy_o and stop_o all low only after an edge where frame_i and irdy_i are both low.
- R11: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_i | input | 1 | Initiator FRAME, active high |
| irdy_i | input | 1 | Initiator ready, active high |
| other_devsel_i | input | 1 | DEVSEL driven by any other agent |
| ad_i | input | AW | Address/data bus as seen by the target |
| cbe_i | input | BW | Command in address phase, byte enables in data phase |
| lock_i | input | 1 | Bridge is locked |
| buf_busy_i | input | 1 | Buffer management activity pending |
| ds_busy_i | input | 1 | Downstream bus owned by another master or DMA |
| devsel_o | output | 1 | Own DEVSEL |
| trdy_o | output | 1 | Target ready |
| stop_o | output | 1 | Target STOP (retry or disconnect) |
| ad_o | output | DW | Read data |
| ad_oe_o | output | 1 | Enable for ad_o onto the bus |
| ds_req_o | output | 1 | Downstream read request |
| ds_addr_o | output | AW | Downstream read address |
| ds_be_o | output | BW | Downstream byte enables |
| ds_ack_i | input | 1 | Downstream read complete |
| ds_data_i | input | DW | Downstream read data |
| ds_bus_req_o | output | 1 | Request for the downstream bus |

## Verification
The bench aims at the edges of the claim window. Another agent's DEVSEL on the very fourth edge must still cancel the claim; a design counting one edge short would claim over that agent and drive DEVSEL alongside it. Each retry cause is applied on its own and in combination. A design that requested the downstream bus on a lock retry, or dropped the request while the bus stayed busy, is caught at ds_bus_req_o. Acknowledge delays equal to, just under and past the standard length separate a correct no-response window from one that is off by one or that hangs waiting. Bursts check that STOP comes with TRDY and holds until FRAME and IRDY are released.

// File: rtl/psr_pkg.sv
package psr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_IGNORE,
        ST_ACCESS,
        ST_DATA,
        ST_TERM,
        ST_TURN
    } psr_state_e;

    localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
    localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
    localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;

    function automatic logic is_mem_read(input logic [3:0] cmd);
        return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_RD_MULT) ||
               (cmd == CMD_MEM_RD_LINE);
    endfunction

endpackage

// File: rtl/psr_claim_timer.sv
module psr_claim_timer #(
    parameter int TIMEOUT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic active_i,
    input  logic other_devsel_i,
    output logic other_seen_o,
    output logic expire_o
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        other_seen_o = active_i && other_devsel_i;
        expire_o     = active_i && !other_devsel_i && (q.cnt == LIMIT);
        if (start_i) begin
            d.cnt = CW'(1);
        end else if (active_i && (q.cnt != LIMIT)) begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (q.cnt != '0));

endmodule

// File: rtl/psr_retry_ctl.sv
module psr_retry_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic eval_i,
    input  logic lock_i,
    input  logic buf_busy_i,
    input  logic ds_busy_i,
    output logic retry_o,
    output logic bus_req_o
);
    typedef struct packed {
        logic bus_req;
    } rty_t;

    rty_t q, d;

    always_comb begin
        d = q;
        retry_o = lock_i || buf_busy_i || ds_busy_i;
        if (eval_i && ds_busy_i) begin
            d.bus_req = 1'b1;
        end else if (!ds_busy_i) begin
            d.bus_req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_req_o = q.bus_req;

    // R5
    busy_retry_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && ds_busy_i) |=> bus_req_o);

    // R5
    req_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_busy_i) |=> !bus_req_o);

endmodule

// File: rtl/psr_ds_port.sv
module psr_ds_port #(
    parameter int AW      = 32,
    parameter int BW      = 4,
    parameter int STD_LEN = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [BW-1:0] be_i,
    input  logic          ack_i,
    output logic          req_o,
    output logic [AW-1:0] addr_o,
    output logic [BW-1:0] be_o,
    output logic          done_o
);
    localparam int CW = $clog2(STD_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(STD_LEN - 1);

    typedef struct packed {
        logic          req;
        logic [AW-1:0] addr;
        logic [BW-1:0] be;
        logic [CW-1:0] cnt;
    } dsp_t;

    dsp_t q, d;

    always_comb begin
        d = q;
        done_o = q.req && (ack_i || (q.cnt == LAST));
        if (start_i) begin
            d.req  = 1'b1;
            d.addr = addr_i;
            d.be   = be_i;
            d.cnt  = '0;
        end else if (q.req) begin
            if (done_o) d.req = 1'b0;
            else        d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_o  = q.req;
    assign addr_o = q.addr;
    assign be_o   = q.be;

    // R6
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> ($stable(addr_o) && $stable(be_o)));

    // R8
    window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (q.cnt <= LAST));

endmodule

// File: rtl/pci_subtr_rd_tgt.sv
module pci_subtr_rd_tgt
    import psr_pkg::*;
#(
    parameter int AW             = 32,
    parameter int DW             = 32,
    parameter int BW             = 4,
    parameter int DEVSEL_TIMEOUT = 4,
    parameter int DS_STD_LEN     = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_i,
    input  logic          irdy_i,
    input  logic          other_devsel_i,
    input  logic [AW-1:0] ad_i,
    input  logic [BW-1:0] cbe_i,
    input  logic          lock_i,
    input  logic          buf_busy_i,
    input  logic          ds_busy_i,
    output logic          devsel_o,
    output logic          trdy_o,
    output logic          stop_o,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe_o,
    output logic          ds_req_o,
    output logic [AW-1:0] ds_addr_o,
    output logic [BW-1:0] ds_be_o,
    input  logic          ds_ack_i,
    input  logic [DW-1:0] ds_data_i,
    output logic          ds_bus_req_o
);
    typedef struct packed {
        psr_state_e    state;
        logic          devsel;
        logic          trdy;
        logic          stop;
        logic [DW-1:0] data;
        logic [AW-1:0] addr;
    } tgt_t;

    tgt_t q, d;

    logic start_rd, other_seen, claim, retry, accept, ds_done;
    logic bus_idle;

    assign bus_idle = !frame_i && !irdy_i;
    assign start_rd = (q.state == ST_IDLE) && frame_i && is_mem_read(cbe_i[3:0]);
    assign accept   = claim && !retry;

    psr_claim_timer #(.TIMEOUT(DEVSEL_TIMEOUT)) u_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_rd),
        .active_i       (q.state == ST_WAIT),
        .other_devsel_i (other_devsel_i),
        .other_seen_o   (other_seen),
        .expire_o       (claim)
    );

    psr_retry_ctl u_retry (
        .clk        (clk),
        .rst_n      (rst_n),
        .eval_i     (claim),
        .lock_i     (lock_i),
        .buf_busy_i (buf_busy_i),
        .ds_busy_i  (ds_busy_i),
        .retry_o    (retry),
        .bus_req_o  (ds_bus_req_o)
    );

    psr_ds_port #(.AW(AW), .BW(BW), .STD_LEN(DS_STD_LEN)) u_ds (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .addr_i  (q.addr),
        .be_i    (cbe_i),
        .ack_i   (ds_ack_i),
        .req_o   (ds_req_o),
        .addr_o  (ds_addr_o),
        .be_o    (ds_be_o),
        .done_o  (ds_done)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (frame_i) begin
                    if (start_rd) begin
                        d.state = ST_WAIT;
                        d.addr  = ad_i;
                    end else begin
                        d.state = ST_IGNORE;
                    end
                end
            end
            ST_WAIT: begin
                if (other_seen) begin
                    d.state = ST_IGNORE;
                end else if (claim) begin
                    d.devsel = 1'b1;
                    if (retry) begin
                        d.stop  = 1'b1;
                        d.state = ST_TERM;
                    end else begin
                        d.state = ST_ACCESS;
                    end
                end
            end
            ST_IGNORE: begin
                if (bus_idle) d.state = ST_IDLE;
            end
            ST_ACCESS: begin
                if (ds_done) begin
                    d.data  = ds_data_i;
                    d.trdy  = 1'b1;
                    d.stop  = frame_i;
                    d.state = ST_DATA;
                end
            end
            ST_DATA: begin
                if (irdy_i) begin
                    d.trdy = 1'b0;
                    if (q.stop) begin
                        d.state = ST_TERM;
                    end else begin
                        d.devsel = 1'b0;
                        d.state  = ST_TURN;
                    end
                end
            end
            ST_TERM: begin
                if (bus_idle) begin
                    d.devsel = 1'b0;
                    d.stop   = 1'b0;
                    d.state  = ST_IDLE;
                end
            end
            ST_TURN: begin
                if (bus_idle) d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign devsel_o = q.devsel;
    assign trdy_o   = q.trdy;
    assign stop_o   = q.stop;
    assign ad_o     = q.data;
    assign ad_oe_o  = (q.state == ST_DATA);

    // R2
    other_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_WAIT) && other_devsel_i) |=> !devsel_o);

    // R7
    single_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy_o && irdy_i) |=> !trdy_o);

    // R4
    stop_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_o && !trdy_o) |-> !ds_req_o);

    // R7
    trdy_has_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trdy_o |-> devsel_o);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE) |-> !(devsel_o || trdy_o || stop_o));

endmodule

// File: tb/pci_subtr_rd_tgt_tb.sv
module pci_subtr_rd_tgt_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STD_LEN    = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_i = 1'b0, irdy_i = 1'b0, other_devsel_i = 1'b0;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_i = '0;
    logic        lock_i = 1'b0, buf_busy_i = 1'b0, ds_busy_i = 1'b0;
    logic        devsel_o, trdy_o, stop_o, ad_oe_o, ds_req_o, ds_bus_req_o;
    logic [31:0] ad_o, ds_addr_o;
    logic [3:0]  ds_be_o;
    logic        ds_ack_i = 1'b0;
    logic [31:0] ds_data_i = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_subtr_rd_tgt #(.DS_STD_LEN(STD_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .irdy_i(irdy_i),
        .other_devsel_i(other_devsel_i), .ad_i(ad_i), .cbe_i(cbe_i),
        .lock_i(lock_i), .buf_busy_i(buf_busy_i), .ds_busy_i(ds_busy_i),
        .devsel_o(devsel_o), .trdy_o(trdy_o), .stop_o(stop_o), .ad_o(ad_o),
        .ad_oe_o(ad_oe_o), .ds_req_o(ds_req_o), .ds_addr_o(ds_addr_o),
        .ds_be_o(ds_be_o), .ds_ack_i(ds_ack_i), .ds_data_i(ds_data_i),
        .ds_bus_req_o(ds_bus_req_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit read_cmd(input logic [3:0] c);
        return (c == 4'b0110) || (c == 4'b1100) || (c == 4'b1110);
    endfunction

    // 0: not claimed, 1: retried, 2: accepted
    function automatic int exp_kind(input logic [3:0] c, input int other,
                                    input bit lk, input bit bf, input bit bz);
        if (!read_cmd(c) || other != 0) return 0;
        if (lk || bf || bz) return 1;
        return 2;
    endfunction

    task automatic run_txn(input logic [3:0] cmd, input logic [31:0] addr,
                           input logic [3:0] be, input bit burst, input int other,
                           input bit lk, input bit bf, input bit bz,
                           input int ackd, input logic [31:0] data);
        int kind;
        int k;
        kind = exp_kind(cmd, other, lk, bf, bz);
        frame_i = 1'b1; irdy_i = 1'b0; ad_i = addr; cbe_i = cmd;
        lock_i = lk; buf_busy_i = bf; ds_busy_i = bz;
        step();
        cbe_i = be; irdy_i = 1'b1; frame_i = burst; ad_i = '0;
        for (int j = 1; j <= 4; j++) begin
            if (other == j) other_devsel_i = 1'b1;
            step();
            if (j < 4) chk("R1", "devsel before timeout", devsel_o, 1'b0);
        end
        if (kind == 0) begin
            chk(read_cmd(cmd) ? "R2" : "R3", "devsel", devsel_o, 1'b0);
            chk(read_cmd(cmd) ? "R2" : "R3", "stop/trdy/req",
                {stop_o, trdy_o, ds_req_o}, 3'b000);
            chk("R5", "no bus request", ds_bus_req_o, 1'b0);
            frame_i = 1'b0; irdy_i = 1'b0; other_devsel_i = 1'b0;
            step();
            chk(read_cmd(cmd) ? "R2" : "R3", "quiet after",
                {devsel_o, stop_o, trdy_o, ds_req_o}, 4'b0000);
        end else if (kind == 1) begin
            chk("R4", "retry devsel/stop/trdy", {devsel_o, stop_o, trdy_o}, 3'b110);
            chk("R4", "no downstream req", ds_req_o, 1'b0);
            frame_i = 1'b0; irdy_i = 1'b0;
            step();
            chk("R10", "idle after retry", {devsel_o, stop_o, trdy_o}, 3'b000);
            chk("R5", "bus request", ds_bus_req_o, bz);
            ds_busy_i = 1'b0;
            step();
            chk("R5", "bus request cleared", ds_bus_req_o, 1'b0);
        end else begin
            chk("R1", "claim devsel", devsel_o, 1'b1);
            chk("R6", "accept trdy/stop", {trdy_o, stop_o}, 2'b00);
            chk("R6", "ds_req", ds_req_o, 1'b1);
            chk("R6", "ds_addr", ds_addr_o, addr);
            chk("R6", "ds_be", ds_be_o, be);
            ds_data_i = data;
            k = (ackd <= STD_LEN) ? ackd : STD_LEN;
            for (int n = 1; n <= k; n++) begin
                if (n == ackd) ds_ack_i = 1'b1;
                step();
                ds_ack_i = 1'b0;
                if (n < k) begin
                    chk("R6", "wait trdy", trdy_o, 1'b0);
                    chk("R6", "ds_req held", ds_req_o, 1'b1);
                    chk("R6", "ds_addr held", ds_addr_o, addr);
                end
            end
            chk(ackd <= STD_LEN ? "R7" : "R8", "trdy", trdy_o, 1'b1);
            chk(ackd <= STD_LEN ? "R7" : "R8", "data", ad_o, data);
            chk("R7", "ad_oe", ad_oe_o, 1'b1);
            chk("R9", "stop with trdy", stop_o, burst);
            chk("R6", "ds_req dropped", ds_req_o, 1'b0);
            step();
            chk("R7", "trdy one transfer", trdy_o, 1'b0);
            chk("R9", "stop held", stop_o, burst);
            chk("R9", "devsel held", devsel_o, burst);
            frame_i = 1'b0; irdy_i = 1'b0;
            step();
            chk("R10", "idle", {devsel_o, stop_o, trdy_o}, 3'b000);
        end
        lock_i = 1'b0; buf_busy_i = 1'b0; ds_busy_i = 1'b0; other_devsel_i = 1'b0;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] cmds [0:4];
        void'($urandom(32'd2024));
        cmds[0] = 4'b0110; cmds[1] = 4'b1100; cmds[2] = 4'b1110;
        cmds[3] = 4'b0111; cmds[4] = 4'b0010;
        repeat (3) @(negedge clk);
        chk("R11", "reset outputs",
            {devsel_o, trdy_o, stop_o, ad_oe_o, ds_req_o, ds_bus_req_o}, 6'b0);
        rst_n = 1'b1;
        step();
        chk("R11", "after reset release", {devsel_o, trdy_o, stop_o}, 3'b000);

        // directed corner cases
        run_txn(4'b0110, 32'h1000_0040, 4'h0, 1'b0, 0, 0, 0, 0, 1, 32'hCAFE_0001);
        run_txn(4'b1100, 32'h2000_0010, 4'h3, 1'b1, 0, 0, 0, 0, 3, 32'h1234_5678);
        run_txn(4'b1110, 32'h3000_0000, 4'hC, 1'b0, 0, 0, 0, 0, 20, 32'hFFFF_FFFF);
        run_txn(4'b0110, 32'h3000_0004, 4'h0, 1'b1, 0, 0, 0, 0, STD_LEN, 32'h0BAD_F00D);
        run_txn(4'b0110, 32'h3000_0008, 4'h0, 1'b0, 0, 0, 0, 0, STD_LEN - 1, 32'h5555_AAAA);
        run_txn(4'b0110, 32'h4000_0000, 4'h0, 1'b0, 4, 0, 0, 0, 1, 32'h0);
        run_txn(4'b0110, 32'h4000_0004, 4'h0, 1'b0, 1, 0, 0, 0, 1, 32'h0);
        run_txn(4'b0111, 32'h5000_0000, 4'h0, 1'b0, 0, 0, 0, 0, 1, 32'h0);
        run_txn(4'b0110, 32'h6000_0000, 4'h0, 1'b0, 0, 1, 0, 0, 1, 32'h0);
        run_txn(4'b0110, 32'h6000_0004, 4'h0, 1'b0, 0, 0, 1, 0, 1, 32'h0);
        run_txn(4'b0110, 32'h6000_0008, 4'h0, 1'b1, 0, 0, 0, 1, 1, 32'h0);
        run_txn(4'b0110, 32'h6000_000C, 4'h0, 1'b0, 0, 1, 0, 1, 1, 32'h0);

        // R5: request persists while the bus stays busy
        frame_i = 1'b1; ad_i = 32'h7000_0000; cbe_i = 4'b0110; ds_busy_i = 1'b1;
        step();
        irdy_i = 1'b1; frame_i = 1'b0;
        repeat (4) step();
        chk("R4", "busy retry stop", stop_o, 1'b1);
        irdy_i = 1'b0;
        step();
        repeat (3) step();
        chk("R5", "request held while busy", ds_bus_req_o, 1'b1);
        ds_busy_i = 1'b0;
        step();
        chk("R5", "request dropped", ds_bus_req_o, 1'b0);

        // constrained random transactions
        for (int t = 0; t < 120; t++) begin
            logic [3:0] c;
            int oth;
            bit lk, bf, bz;
            c   = cmds[$urandom_range(4, 0) % 5];
            if ($urandom_range(3, 0) == 0) c = cmds[0];
            oth = ($urandom_range(3, 0) == 0) ? $urandom_range(4, 1) : 0;
            lk  = ($urandom_range(7, 0) == 0);
            bf  = ($urandom_range(7, 0) == 0);
            bz  = ($urandom_range(7, 0) == 0);
            run_txn(c, $urandom, 4'($urandom), 1'($urandom), oth, lk, bf, bz,
                    $urandom_range(STD_LEN + 2, 1), $urandom);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule